// File: doc/BRIEF.md
# Trace Enable Packet Sequencer

This block sits between the trace control bits and a downstream packet encoder. It follows a trace-enable bit and a packet-enable qualifier. From their transitions it produces an ordered stream of packet-generation requests. Each request carries a three-bit packet-type code and moves over a valid/ready handshake. A small queue holds requests while the encoder is busy, so that events arriving close together are kept and stay in order.

When trace enable turns on, the block requests packets that tell the encoder how the trace restarts. If the output byte count is zero, it requests one full synchronization burst. If the count is non-zero, it requests a set of timing packets instead. When packet enable turns on while tracing is on, it requests a generation-enable packet. When trace enable turns off, the block requests a generation-disable packet only if packet enable is high in that cycle. It then waits for its own queue to empty and asks the encoder to flush its buffered bytes. After the encoder confirms the flush, it raises a flag that tells software the output pointers can be read safely.

Top module: `trc_pkt_seq`

## Requirements
- R1: A rising trace_en with byte_cnt equal to zero queues exactly one request with code 0 (synchronization burst).
- R2: A rising trace_en with a non-zero byte_cnt queues three requests in this order: code 1 (timestamp), code 2 (clock alignment), code 3 (bus ratio).
- R3: A rising pkt_en while trace_en is 1 queues code 4 (generation enable). When it coincides with a rising trace_en, code 4 comes after the enable packets. A rising pkt_en while trace_en is 0 queues nothing.
- R4: A falling trace_en queues code 5 (generation disable) when pkt_en is 1 in that cycle, and nothing when pkt_en is 0. A disable queues no other code.
- R5: While req_ready is low, req_valid stays high and req_code stays unchanged. Queued requests are delivered in order and none are dropped while the queue depth is not exceeded.
- R6: After trace_en falls, flush_req rises only once no request is pending. It stays high until flush_done is seen.
- R7: outputs_stable rises in the cycle after flush_done is accepted while flush_req is high. It clears after the next rising trace_en.
- R8: After reset, req_valid, flush_req and outputs_stable are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Trace enable bit |
| pkt_en | input | 1 | Packet enable qualifier |
| byte_cnt | input | BYTE_W | Output packet byte count |
| req_valid | output | 1 | A packet request is offered |
| req_ready | input | 1 | Encoder accepts the offered request |
| req_code | output | 3 | Packet-type code of the offered request |
| flush_req | output | 1 | Request to flush buffered packet bytes |
| flush_done | input | 1 | Encoder reports the flush is complete |
| outputs_stable | output | 1 | Output pointers are stable after a disable |

## Verification
Two events can land in one cycle: a rising trace enable and a rising packet enable. In that case both the enable packets and the generation-enable packet go into the queue on the same edge, and their order is set by slot position. The stimulus table raises both inputs together, with the byte count both zero and non-zero. It also drops trace enable in the same cycle that packet enable rises or falls. Each case is judged by comparing the full sequence of accepted codes with the expected list. A directed test holds ready low across both an enable and a disable, then checks that the five queued codes arrive in order before any flush is requested.

// File: rtl/trc_seq_pkg.sv
package trc_seq_pkg;
  localparam int CODE_W   = 3;
  localparam int MAX_PUSH = 4;
  localparam int PUSH_W   = 3;

  typedef enum logic [CODE_W-1:0] {
    PK_SYNC    = 3'd0,
    PK_TSTAMP  = 3'd1,
    PK_ALIGN   = 3'd2,
    PK_RATIO   = 3'd3,
    PK_GEN_ON  = 3'd4,
    PK_GEN_OFF = 3'd5
  } pkt_code_e;

  typedef enum logic [1:0] {
    FL_IDLE,
    FL_DRAIN,
    FL_FLUSH,
    FL_STABLE
  } flush_st_e;

  // number of packets requested by an enable edge
  function automatic logic [PUSH_W-1:0] enable_burst_len(input logic cnt_zero);
    return cnt_zero ? PUSH_W'(1) : PUSH_W'(3);
  endfunction

  // timing packet k of the non-zero-count burst
  function automatic pkt_code_e timing_code(input int k);
    case (k)
      0:       return PK_TSTAMP;
      1:       return PK_ALIGN;
      default: return PK_RATIO;
    endcase
  endfunction
endpackage

// File: rtl/trc_seq_edges.sv
module trc_seq_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic trace_en,
  input  logic pkt_en,
  output logic te_rise,
  output logic te_fall,
  output logic pe_rise
);
  logic te_q, pe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      te_q <= 1'b0;
      pe_q <= 1'b0;
    end else begin
      te_q <= trace_en;
      pe_q <= pkt_en;
    end
  end

  assign te_rise = trace_en & ~te_q;
  assign te_fall = ~trace_en & te_q;
  assign pe_rise = pkt_en & ~pe_q;
endmodule

// File: rtl/trc_seq_events.sv
module trc_seq_events
  import trc_seq_pkg::*;
(
  input  logic                                  te_rise,
  input  logic                                  te_fall,
  input  logic                                  pe_rise,
  input  logic                                  trace_en,
  input  logic                                  pkt_en,
  input  logic                                  cnt_zero,
  output logic [PUSH_W-1:0]                     push_cnt,
  output logic [MAX_PUSH-1:0][CODE_W-1:0]       push_codes
);
  logic [PUSH_W-1:0] n;

  always_comb begin
    n          = '0;
    push_codes = '0;
    if (te_rise) begin
      if (cnt_zero) begin
        push_codes[0] = PK_SYNC;
      end else begin
        for (int k = 0; k < 3; k++) push_codes[k] = timing_code(k);
      end
      n = enable_burst_len(cnt_zero);
    end
    if (pe_rise && trace_en) begin
      push_codes[n[1:0]] = PK_GEN_ON;
      n = n + PUSH_W'(1);
    end
    if (te_fall && pkt_en) begin
      push_codes[0] = PK_GEN_OFF;
      n = PUSH_W'(1);
    end
    push_cnt = n;
  end
endmodule

// File: rtl/trc_seq_fifo.sv
module trc_seq_fifo
  import trc_seq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [PUSH_W-1:0]               push_cnt,
  input  logic [MAX_PUSH-1:0][CODE_W-1:0] push_codes,
  input  logic                            pop,
  output logic [CODE_W-1:0]               head_code,
  output logic                            empty,
  output logic [CNT_W-1:0]                free
);
  logic [CODE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;

  always_ff @(posedge clk) begin
    for (int i = 0; i < MAX_PUSH; i++) begin
      if (PUSH_W'(i) < push_cnt) mem[wr_ptr + PTR_W'(i)] <= push_codes[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(push_cnt);
      rd_ptr <= rd_ptr + PTR_W'(pop);
      count  <= count + CNT_W'(push_cnt) - CNT_W'(pop);
    end
  end

  assign head_code = mem[rd_ptr];
  assign empty     = (count == '0);
  assign free      = CNT_W'(DEPTH) - count;
endmodule

// File: rtl/trc_seq_flush.sv
module trc_seq_flush
  import trc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic te_rise,
  input  logic te_fall,
  input  logic queue_empty,
  input  logic flush_done,
  output logic flush_req,
  output logic outputs_stable
);
  flush_st_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= FL_IDLE;
    end else if (te_rise) begin
      state <= FL_IDLE;
    end else begin
      case (state)
        FL_IDLE:   if (te_fall)     state <= FL_DRAIN;
        FL_DRAIN:  if (queue_empty) state <= FL_FLUSH;
        FL_FLUSH:  if (flush_done)  state <= FL_STABLE;
        default:                    state <= state;
      endcase
    end
  end

  assign flush_req      = (state == FL_FLUSH);
  assign outputs_stable = (state == FL_STABLE);
endmodule

// File: rtl/trc_pkt_seq.sv
module trc_pkt_seq
  import trc_seq_pkg::*;
#(
  parameter int BYTE_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic              pkt_en,
  input  logic [BYTE_W-1:0] byte_cnt,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [2:0]        req_code,
  output logic              flush_req,
  input  logic              flush_done,
  output logic              outputs_stable
);
  localparam int FCNT_W = $clog2(DEPTH + 1);

  // named internal events, observed by the checker
  logic                            te_rise, te_fall, pe_rise;
  logic [PUSH_W-1:0]               push_cnt;
  logic [MAX_PUSH-1:0][CODE_W-1:0] push_codes;
  logic [FCNT_W-1:0]               fifo_free;
  logic                            fifo_empty;
  logic                            pop;

  trc_seq_edges u_edges (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .pkt_en(pkt_en),
    .te_rise(te_rise), .te_fall(te_fall), .pe_rise(pe_rise)
  );

  trc_seq_events u_events (
    .te_rise(te_rise), .te_fall(te_fall), .pe_rise(pe_rise),
    .trace_en(trace_en), .pkt_en(pkt_en), .cnt_zero(byte_cnt == '0),
    .push_cnt(push_cnt), .push_codes(push_codes)
  );

  trc_seq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_cnt(push_cnt), .push_codes(push_codes),
    .pop(pop), .head_code(req_code), .empty(fifo_empty), .free(fifo_free)
  );

  trc_seq_flush u_flush (
    .clk(clk), .rst_n(rst_n), .te_rise(te_rise), .te_fall(te_fall),
    .queue_empty(fifo_empty), .flush_done(flush_done),
    .flush_req(flush_req), .outputs_stable(outputs_stable)
  );

  assign req_valid = ~fifo_empty;
  assign pop       = req_valid & req_ready;
endmodule

// File: rtl/trc_seq_chk.sv
module trc_seq_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trace_en,
  input logic             pkt_en,
  input logic             req_valid,
  input logic             req_ready,
  input logic [2:0]       req_code,
  input logic             flush_req,
  input logic             flush_done,
  input logic             outputs_stable,
  input logic             te_rise,
  input logic             te_fall,
  input logic [2:0]       push_cnt,
  input logic [CNT_W-1:0] fifo_free
);
  // R1
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_code <= 3'd5);

  // R4
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    te_fall |-> push_cnt == (pkt_en ? 3'd1 : 3'd0));

  // R5
  hold_under_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_code));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(push_cnt) <= int'(fifo_free));

  // R6
  flush_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !req_valid);

  // R6
  flush_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_done && !trace_en |=> flush_req);

  // R7
  stable_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outputs_stable) |-> $past(flush_req && flush_done));

  // R7
  stable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    te_rise |=> !outputs_stable);
endmodule

bind trc_pkt_seq trc_seq_chk #(.CNT_W($clog2(DEPTH + 1))) u_chk (
  .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .pkt_en(pkt_en),
  .req_valid(req_valid), .req_ready(req_ready), .req_code(req_code),
  .flush_req(flush_req), .flush_done(flush_done), .outputs_stable(outputs_stable),
  .te_rise(te_rise), .te_fall(te_fall), .push_cnt(push_cnt), .fifo_free(fifo_free)
);

// File: tb/trc_pkt_seq_tb.sv
module trc_pkt_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trace_en = 1'b0, pkt_en = 1'b0;
  logic [31:0] byte_cnt = '0;
  logic        req_valid, req_ready = 1'b0;
  logic [2:0]  req_code;
  logic        flush_req, flush_done = 1'b0, outputs_stable;

  int checks = 0, errors = 0;
  int seen [16];
  int seen_n = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  trc_pkt_seq u_dut (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .pkt_en(pkt_en),
    .byte_cnt(byte_cnt), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .flush_req(flush_req), .flush_done(flush_done),
    .outputs_stable(outputs_stable)
  );

  // accepted requests: valid&ready at a falling edge is taken at the next rising edge
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (seen_n < 16) seen[seen_n] = int'(req_code);
      seen_n++;
    end
  end

  // {zero_cnt, pe_with_enable, pe_at_disable, count[2:0], c5..c0}
  localparam logic [23:0] VEC [6] = '{
    {3'b100, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
    {3'b000, 3'd3, 3'd0, 3'd0, 3'd0, 3'd3, 3'd2, 3'd1},
    {3'b111, 3'd3, 3'd0, 3'd0, 3'd0, 3'd5, 3'd4, 3'd0},
    {3'b011, 3'd5, 3'd0, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1},
    {3'b010, 3'd4, 3'd0, 3'd0, 3'd4, 3'd3, 3'd2, 3'd1},
    {3'b101, 3'd2, 3'd0, 3'd0, 3'd0, 3'd0, 3'd5, 3'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic string tag_of(input int code);
    case (code)
      0:       return "R1 sync code";
      4:       return "R3 gen-enable code";
      5:       return "R4 gen-disable code";
      default: return "R2 timing code";
    endcase
  endfunction

  task automatic wait_flush();
    for (int w = 0; w < 30 && !flush_req; w++) tick(1);
    chk(flush_req == 1'b1, "R6 flush_req raised", int'(flush_req), 1);
  endtask

  task automatic do_flush();
    flush_done = 1'b1;
    tick(1);
    flush_done = 1'b0;
    @(negedge clk);
    chk(outputs_stable == 1'b1, "R7 stable after flush_done", int'(outputs_stable), 1);
    chk(flush_req == 1'b0, "R6 flush_req dropped", int'(flush_req), 0);
  endtask

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    errors++;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R8
    chk(req_valid == 1'b0, "R8 reset valid", int'(req_valid), 0);
    chk(flush_req == 1'b0, "R8 reset flush_req", int'(flush_req), 0);
    chk(outputs_stable == 1'b0, "R8 reset stable", int'(outputs_stable), 0);

    // R3: packet enable rising with trace off requests nothing
    req_ready = 1'b1;
    pkt_en = 1'b1;
    tick(3);
    @(negedge clk);
    chk(seen_n == 0 && !req_valid, "R3 no request while trace off", seen_n, 0);
    pkt_en = 1'b0;
    tick(2);

    // stimulus table
    for (int v = 0; v < 6; v++) begin
      logic [23:0] e;
      e = VEC[v];
      seen_n = 0;
      byte_cnt = e[23] ? 32'd0 : 32'd37 + 32'(v);
      req_ready = 1'b1;
      trace_en = 1'b1;
      pkt_en = e[22];
      tick(1);
      @(negedge clk);
      if (v > 0) chk(outputs_stable == 1'b0, "R7 stable cleared on enable", int'(outputs_stable), 0);
      tick(8);
      trace_en = 1'b0;
      pkt_en = e[21];
      wait_flush();
      do_flush();
      chk(seen_n == int'(e[20:18]), "R4 request count for table row", seen_n, int'(e[20:18]));
      for (int k = 0; k < int'(e[20:18]) && k < seen_n; k++) begin
        int exp_c;
        exp_c = int'(e[3*k +: 3]);
        chk(seen[k] == exp_c, tag_of(exp_c), seen[k], exp_c);
      end
      pkt_en = 1'b0;
      tick(2);
    end

    // R5/R6: backpressure across enable and disable
    seen_n = 0;
    req_ready = 1'b0;
    byte_cnt = 32'd9;
    trace_en = 1'b1;
    pkt_en = 1'b1;
    tick(4);
    @(negedge clk);
    chk(req_valid == 1'b1, "R5 valid held", int'(req_valid), 1);
    chk(req_code == 3'd1, "R5 head code held", int'(req_code), 1);
    trace_en = 1'b0;
    tick(3);
    @(negedge clk);
    chk(flush_req == 1'b0, "R6 no flush while pending", int'(flush_req), 0);
    chk(seen_n == 0, "R5 nothing accepted under backpressure", seen_n, 0);
    req_ready = 1'b1;
    wait_flush();
    chk(seen_n == 5, "R5 all queued requests delivered", seen_n, 5);
    for (int k = 0; k < 5 && k < seen_n; k++)
      chk(seen[k] == k + 1, "R5 delivery order", seen[k], k + 1);
    tick(3);
    @(negedge clk);
    chk(flush_req == 1'b1, "R6 flush_req held until done", int'(flush_req), 1);
    chk(outputs_stable == 1'b0, "R7 not stable before done", int'(outputs_stable), 0);
    do_flush();
    pkt_en = 1'b0;
    tick(2);

    // R3: packet enable rising later while trace on
    seen_n = 0;
    byte_cnt = 32'd0;
    trace_en = 1'b1;
    tick(4);
    pkt_en = 1'b1;
    tick(4);
    @(negedge clk);
    chk(seen_n == 2, "R3 late enable count", seen_n, 2);
    chk(seen[0] == 0, "R1 sync first", seen[0], 0);
    chk(seen[1] == 4, "R3 late gen-enable", seen[1], 4);
    pkt_en = 1'b0;
    tick(2);
    pkt_en = 1'b1;
    tick(3);
    @(negedge clk);
    chk(seen_n == 3 && seen[2] == 4, "R3 second gen-enable", seen[2], 4);
    trace_en = 1'b0;
    pkt_en = 1'b0;
    wait_flush();
    do_flush();
    chk(seen_n == 3, "R4 no packet on disable with pkt_en low", seen_n, 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule